// File: doc/BRIEF.md
# Add/Subtract Unit with Condition Flags

A purely combinational integer unit that adds two operands, subtracts the second from the first, or subtracts the first from the second. All three operations go through a single ripple adder. For the two subtract forms the subtrahend is inverted and a carry of one is injected, which is the two's-complement negation of the subtrahend. Next to the result the unit produces four condition flags: negative, zero, carry and signed overflow.

An optional carry input lets software-visible wide arithmetic be built one word at a time. With chaining enabled, the stored carry flag of the previous word replaces the implicit carry-in. For subtraction the carry flag means "no borrow": a clear carry borrows one from the current word. Instruction decode, logic operations, shifts and operand storage belong to surrounding blocks.

Top module: `addsub_flags_unit`

## Requirements
- R1: With `op_sel` = 2'b00 (add), `result` equals (`opnd_x` + `opnd_m` + k) modulo 2^W and `flag_c` is the carry out of the top bit, where k is `carry_in` when `chain_en` = 1 and 0 otherwise.
- R2: With `op_sel` = 2'b01 (subtract), `result` equals (`opnd_x` − `opnd_m` − b) modulo 2^W, where b = 1 − `carry_in` when chained and 0 otherwise; `flag_c` is 1 exactly when that difference, taken on unsigned values, is not negative.
- R3: With `op_sel` = 2'b10 (reverse subtract), `result` equals (`opnd_m` − `opnd_x` − b) modulo 2^W with b as in R2, and `flag_c` is 1 exactly when that unsigned difference is not negative.
- R4: For operations 2'b00 to 2'b10, `flag_v` is 1 exactly when the true result, taken on two's-complement operands, lies outside [−2^(W−1), 2^(W−1)−1].
- R5: `flag_n` equals the top bit (bit W−1) of `result`.
- R6: `flag_z` is 1 exactly when every bit of `result` is zero.
- R7: With `chain_en` = 1, `carry_in` takes the place of the constant carry-in (0 for add, 1 for both subtract forms), so a 2W-bit add or subtract is obtained by feeding the low word's `flag_c` into the high word's `carry_in`.
- R8: `op_sel` = 2'b11 is reserved: `result` is zero and all four flags are zero, whatever the other inputs.
- R9: With `chain_en` = 0, `carry_in` has no effect on `result` or on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 2 | Operation: 00 add, 01 X−M, 10 M−X, 11 reserved |
| chain_en | input | 1 | Use `carry_in` instead of the constant carry-in |
| carry_in | input | 1 | Incoming carry (inverted borrow for subtraction) |
| opnd_x | input | W (32) | First operand X |
| opnd_m | input | W (32) | Second operand M |
| result | output | W (32) | Arithmetic result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / not-borrow flag |
| flag_v | output | 1 | Signed overflow flag |

## Verification
The checker has no clock and tests the outputs whenever the inputs change. It therefore assumes every input holds a defined 0 or 1 value, and that the width stays below 62 bits, so that its 64-bit signed reference arithmetic cannot wrap. The bench gives every input an initial value before time zero and changes the inputs only between samples. It sweeps a 4-bit copy of the unit over every operation, every operand pair, and both chaining and carry settings. The 32-bit instance gets the signed and unsigned boundary values and two-word chains.

// File: rtl/addsub_pkg.sv
// Package: shared types of the add/subtract unit.
// Assumes: nothing beyond IEEE 1800-2017 packed types.
package addsub_pkg;

    // Operation select; the encoding is visible at the top-level port.
    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_SUB  = 2'b01,
        OP_RSB  = 2'b10,
        OP_NONE = 2'b11
    } arith_op_e;

    // Condition flags in one bundle.
    typedef struct packed {
        logic neg;
        logic zero;
        logic carry;
        logic ovf;
    } cond_flags_t;

endpackage

// File: rtl/addsub_operand_mux.sv
// Module: addsub_operand_mux
// Routes the operands into the single adder. Subtract forms invert the
// subtrahend. The carry-in is the constant (0 add, 1 subtract) unless
// chaining selects the external carry.
// Assumes: op is one of the four encodings; reserved is flagged as invalid.
module addsub_operand_mux
    import addsub_pkg::*;
#(
    parameter int W = 32
) (
    input  arith_op_e      op,
    input  logic           chain_en,
    input  logic           carry_in,
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   m,
    output logic [W-1:0]   add_a,
    output logic [W-1:0]   add_b,
    output logic           add_cin,
    output logic           op_valid
);

    // Select adder inputs and carry-in for the requested operation.
    always_comb begin
        add_a    = x;
        add_b    = m;
        add_cin  = chain_en ? carry_in : 1'b0;
        op_valid = 1'b1;
        unique case (op)
            OP_ADD: begin
                add_a   = x;
                add_b   = m;
                add_cin = chain_en ? carry_in : 1'b0;
            end
            OP_SUB: begin
                add_a   = x;
                add_b   = ~m;
                add_cin = chain_en ? carry_in : 1'b1;
            end
            OP_RSB: begin
                add_a   = m;
                add_b   = ~x;
                add_cin = chain_en ? carry_in : 1'b1;
            end
            default: begin
                add_a    = '0;
                add_b    = '0;
                add_cin  = 1'b0;
                op_valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/addsub_ripple_adder.sv
// Module: addsub_ripple_adder
// Bit-level ripple-carry adder built from W full-adder cells. It also
// exposes the carry into the top bit, so overflow can be taken as the XOR
// of the last two carries.
// Assumes: W >= 2.
module addsub_ripple_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         c_into_msb
);

    logic [W:0] carry;

    // Carry chain origin.
    assign carry[0] = cin;

    // One full-adder cell per bit.
    for (genvar i = 0; i < W; i++) begin : g_cell
        assign sum[i]       = a[i] ^ b[i] ^ carry[i];
        assign carry[i + 1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
    end

    // Export the last two carries.
    assign cout       = carry[W];
    assign c_into_msb = carry[W-1];

endmodule

// File: rtl/addsub_flag_gen.sv
// Module: addsub_flag_gen
// Forms the visible result and the N/Z/C/V flags from the adder outputs.
// A reserved operation forces the result and all flags to zero.
// Assumes: the adder operands were already inverted for subtraction, so
// the carry out is the inverted borrow.
module addsub_flag_gen
    import addsub_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] sum,
    input  logic         cout,
    input  logic         c_into_msb,
    input  logic         op_valid,
    output logic [W-1:0] result,
    output cond_flags_t  flags
);

    // Gate the result for reserved operations.
    assign result = op_valid ? sum : '0;

    // Derive the four condition flags.
    always_comb begin
        flags.neg   = result[W-1];
        flags.zero  = op_valid & ~|result;
        flags.carry = op_valid & cout;
        flags.ovf   = op_valid & (cout ^ c_into_msb);
    end

endmodule

// File: rtl/addsub_flags_unit.sv
// Module: addsub_flags_unit (top)
// Combinational add / subtract / reverse-subtract unit with N, Z, C, V.
// All three operations use one ripple adder. Optional carry chaining
// supports multi-word arithmetic.
// Assumes: inputs are stable and defined; the unit has no state.
module addsub_flags_unit
    import addsub_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [1:0]   op_sel,
    input  logic         chain_en,
    input  logic         carry_in,
    input  logic [W-1:0] opnd_x,
    input  logic [W-1:0] opnd_m,
    output logic [W-1:0] result,
    output logic         flag_n,
    output logic         flag_z,
    output logic         flag_c,
    output logic         flag_v
);

    arith_op_e    op;
    logic [W-1:0] add_a;
    logic [W-1:0] add_b;
    logic         add_cin;
    logic         op_valid;
    logic [W-1:0] sum;
    logic         cout;
    logic         c_msb;
    cond_flags_t  flags;

    // Interpret the raw select as an operation.
    assign op = arith_op_e'(op_sel);

    addsub_operand_mux #(.W(W)) mux_i (
        .op       (op),
        .chain_en (chain_en),
        .carry_in (carry_in),
        .x        (opnd_x),
        .m        (opnd_m),
        .add_a    (add_a),
        .add_b    (add_b),
        .add_cin  (add_cin),
        .op_valid (op_valid)
    );

    addsub_ripple_adder #(.W(W)) adder_i (
        .a          (add_a),
        .b          (add_b),
        .cin        (add_cin),
        .sum        (sum),
        .cout       (cout),
        .c_into_msb (c_msb)
    );

    addsub_flag_gen #(.W(W)) flags_i (
        .sum        (sum),
        .cout       (cout),
        .c_into_msb (c_msb),
        .op_valid   (op_valid),
        .result     (result),
        .flags      (flags)
    );

    // Unpack flags onto the ports.
    assign flag_n = flags.neg;
    assign flag_z = flags.zero;
    assign flag_c = flags.carry;
    assign flag_v = flags.ovf;

endmodule

// File: rtl/addsub_flags_unit_chk.sv
// Module: addsub_flags_unit_chk
// Checker bound to every addsub_flags_unit. It recomputes the exact
// result with 64-bit signed arithmetic and compares it against the ports.
// Assumes: W < 62 and defined (0/1) inputs.
module addsub_flags_unit_chk #(
    parameter int W = 32
) (
    input logic [1:0]   op_sel,
    input logic         chain_en,
    input logic         carry_in,
    input logic [W-1:0] opnd_x,
    input logic [W-1:0] opnd_m,
    input logic [W-1:0] result,
    input logic         flag_n,
    input logic         flag_z,
    input logic         flag_c,
    input logic         flag_v
);

    localparam logic signed [63:0] MASK = (64'sd1 <<< W) - 64'sd1;
    localparam logic signed [63:0] HALF = 64'sd1 <<< (W - 1);

    logic signed [63:0] ux, um, sx, sm, kin, kbor, u_ex, s_ex;

    // Exact unsigned and signed reference results.
    always_comb begin
        ux   = $signed({{(64 - W){1'b0}}, opnd_x});
        um   = $signed({{(64 - W){1'b0}}, opnd_m});
        sx   = $signed({{(64 - W){opnd_x[W-1]}}, opnd_x});
        sm   = $signed({{(64 - W){opnd_m[W-1]}}, opnd_m});
        kin  = (chain_en && carry_in) ? 64'sd1 : 64'sd0;
        kbor = (chain_en && !carry_in) ? 64'sd1 : 64'sd0;
        case (op_sel)
            2'b00: begin u_ex = ux + um + kin;  s_ex = sx + sm + kin;  end
            2'b01: begin u_ex = ux - um - kbor; s_ex = sx - sm - kbor; end
            2'b10: begin u_ex = um - ux - kbor; s_ex = sm - sx - kbor; end
            default: begin u_ex = 64'sd0; s_ex = 64'sd0; end
        endcase
    end

    // Port-level properties, one per requirement where expressible.
    always_comb begin
        if (op_sel == 2'b00) begin
            assert_add_R1: assert ($signed({{(64 - W){1'b0}}, result}) == (u_ex & MASK)
                                   && flag_c == (((u_ex >>> W) & 64'sd1) != 0))
                else $error("add result/carry mismatch");
        end
        if (op_sel == 2'b01) begin
            assert_sub_R2: assert ($signed({{(64 - W){1'b0}}, result}) == (u_ex & MASK)
                                   && flag_c == (u_ex >= 0))
                else $error("subtract result/carry mismatch");
        end
        if (op_sel == 2'b10) begin
            assert_rsb_R3: assert ($signed({{(64 - W){1'b0}}, result}) == (u_ex & MASK)
                                   && flag_c == (u_ex >= 0))
                else $error("reverse subtract result/carry mismatch");
        end
        if (op_sel != 2'b11) begin
            assert_overflow_R4: assert (flag_v == ((s_ex < -HALF) || (s_ex > HALF - 64'sd1)))
                else $error("overflow flag mismatch");
            // Without overflow the sign of the exact result is visible.
            assert_sign_R5: assert (flag_v || (flag_n == (s_ex < 0)))
                else $error("negative flag mismatch");
            assert_zero_R6: assert (flag_z == ((u_ex & MASK) == 0))
                else $error("zero flag mismatch");
        end else begin
            assert_reserved_R8: assert (result == '0 && !flag_n && !flag_z && !flag_c && !flag_v)
                else $error("reserved operation produced output");
        end
    end

endmodule

bind addsub_flags_unit addsub_flags_unit_chk #(.W(W)) chk_i (
    .op_sel   (op_sel),
    .chain_en (chain_en),
    .carry_in (carry_in),
    .opnd_x   (opnd_x),
    .opnd_m   (opnd_m),
    .result   (result),
    .flag_n   (flag_n),
    .flag_z   (flag_z),
    .flag_c   (flag_c),
    .flag_v   (flag_v)
);

// File: tb/addsub_flags_unit_tb_top.sv
// Bench: exhaustive sweep of a 4-bit unit plus 32-bit corner cases and
// two-word chains; expected values from plain integer arithmetic.
module addsub_flags_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 50000;
    localparam int WS         = 4;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    int   total = 0;
    int   bad   = 0;
    bit   done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // 32-bit instance signals.
    logic [1:0]  op_l    = 2'b00;
    logic        chain_l = 1'b0;
    logic        cin_l   = 1'b0;
    logic [31:0] x_l     = '0;
    logic [31:0] m_l     = '0;
    logic [31:0] res_l;
    logic        n_l, z_l, c_l, v_l;

    // Small instance signals.
    logic [1:0]    op_s    = 2'b00;
    logic          chain_s = 1'b0;
    logic          cin_s   = 1'b0;
    logic [WS-1:0] x_s     = '0;
    logic [WS-1:0] m_s     = '0;
    logic [WS-1:0] res_s;
    logic          n_s, z_s, c_s, v_s;

    addsub_flags_unit #(.W(32)) dut_i (
        .op_sel(op_l), .chain_en(chain_l), .carry_in(cin_l),
        .opnd_x(x_l), .opnd_m(m_l), .result(res_l),
        .flag_n(n_l), .flag_z(z_l), .flag_c(c_l), .flag_v(v_l)
    );

    addsub_flags_unit #(.W(WS)) dut_small_i (
        .op_sel(op_s), .chain_en(chain_s), .carry_in(cin_s),
        .opnd_x(x_s), .opnd_m(m_s), .result(res_s),
        .flag_n(n_s), .flag_z(z_s), .flag_c(c_s), .flag_v(v_s)
    );

    // Reference model from the requirements.
    function automatic void model(input int w, input int op, input longint x, input longint m,
                                  input bit chain, input bit cin, output longint res,
                                  output bit n, output bit z, output bit c, output bit v);
        longint full = longint'(1) << w;
        longint half = longint'(1) << (w - 1);
        longint sx = (x >= half) ? x - full : x;
        longint sm = (m >= half) ? m - full : m;
        longint k  = (chain && cin) ? 1 : 0;
        longint b  = (chain && !cin) ? 1 : 0;
        longint u = 0;
        longint s = 0;
        case (op)
            0: begin u = x + m + k; s = sx + sm + k; end
            1: begin u = x - m - b; s = sx - sm - b; end
            2: begin u = m - x - b; s = sm - sx - b; end
            default: ;
        endcase
        res = u & (full - 1);
        if (op == 3) begin
            n = 0; z = 0; c = 0; v = 0;
        end else begin
            n = ((res >> (w - 1)) & 1) != 0;
            z = (res == 0);
            c = (op == 0) ? (((u >> w) & 1) != 0) : (u >= 0);
            v = (s < -half) || (s > half - 1);
        end
    endfunction

    task automatic check(input string req, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string res_tag(input int op, input bit chain, input bit cin);
        if (op == 3) return "R8";
        if (chain)   return "R7";
        if (cin)     return "R9";
        if (op == 0) return "R1";
        if (op == 1) return "R2";
        return "R3";
    endfunction

    task automatic compare(input int w, input int op, input longint x, input longint m,
                           input bit chain, input bit cin, input longint r,
                           input bit n, input bit z, input bit c, input bit v);
        longint er;
        bit en, ez, ec, ev;
        string t;
        model(w, op, x, m, chain, cin, er, en, ez, ec, ev);
        t = res_tag(op, chain, cin);
        check(t, "result", r, er);
        check(t, "carry", longint'(c), longint'(ec));
        check((op == 3) ? "R8" : "R4", "ovf", longint'(v), longint'(ev));
        check("R5", "neg", longint'(n), longint'(en));
        check("R6", "zero", longint'(z), longint'(ez));
    endtask

    task automatic run_small(input int op, input int x, input int m, input bit chain, input bit cin);
        @(negedge clk);
        op_s = op[1:0]; x_s = x[WS-1:0]; m_s = m[WS-1:0]; chain_s = chain; cin_s = cin;
        #1;
        compare(WS, op, longint'(x), longint'(m), chain, cin,
                longint'(res_s), n_s, z_s, c_s, v_s);
    endtask

    task automatic run_big(input int op, input logic [31:0] x, input logic [31:0] m,
                           input bit chain, input bit cin);
        @(negedge clk);
        op_l = op[1:0]; x_l = x; m_l = m; chain_l = chain; cin_l = cin;
        #1;
        compare(32, op, longint'(x), longint'(m), chain, cin,
                longint'(res_l), n_l, z_l, c_l, v_l);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] acc;
        logic        lo_c;
        // Reset-time state: zero inputs give zero result with Z set (R6).
        repeat (2) @(posedge clk);
        #1;
        check("R6", "reset result", longint'(res_l), 0);
        check("R6", "reset zero", longint'(z_l), 1);
        rst_n = 1'b1;

        // Exhaustive 4-bit sweep (R1..R9).
        for (int op = 0; op < 4; op++)
            for (int x = 0; x < 16; x++)
                for (int m = 0; m < 16; m++)
                    for (int ch = 0; ch < 2; ch++)
                        for (int ci = 0; ci < 2; ci++)
                            run_small(op, x, m, ch[0], ci[0]);

        // 32-bit boundaries.
        run_big(0, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b0);  // R4 positive overflow
        check("R4", "max+1 ovf", longint'(v_l), 1);
        run_big(1, 32'h8000_0000, 32'h0000_0001, 1'b0, 1'b0);  // R4 negative overflow
        check("R2", "min-1 carry", longint'(c_l), 1);
        run_big(1, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0);  // R6 zero, no borrow
        check("R6", "0-0 zero", longint'(z_l), 1);
        run_big(0, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b0);  // R1 wrap with carry
        run_big(2, 32'h0000_0005, 32'h0000_0003, 1'b0, 1'b0);  // R3 borrow
        check("R3", "rsb borrow", longint'(c_l), 0);
        run_big(0, 32'h0000_0005, 32'h0000_0003, 1'b0, 1'b1);  // R9 carry ignored
        check("R9", "ignored carry", longint'(res_l), 8);
        run_big(3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1);  // R8 reserved

        // Two-word add: 0x1_FFFFFFFF + 0x0_00000001 (R7).
        run_big(0, 32'hFFFF_FFFF, 32'h0000_0001, 1'b1, 1'b0);
        acc[31:0] = res_l; lo_c = c_l;
        run_big(0, 32'h0000_0001, 32'h0000_0000, 1'b1, lo_c);
        acc[63:32] = res_l;
        check("R7", "64-bit add", longint'(acc), 64'h0000_0002_0000_0000);

        // Two-word subtract: 0x1_00000000 - 0x0_00000001 (R7).
        run_big(1, 32'h0000_0000, 32'h0000_0001, 1'b1, 1'b1);
        acc[31:0] = res_l; lo_c = c_l;
        run_big(1, 32'h0000_0001, 32'h0000_0000, 1'b1, lo_c);
        acc[63:32] = res_l;
        check("R7", "64-bit sub", longint'(acc), 64'h0000_0000_FFFF_FFFF);
        check("R7", "64-bit sub carry", longint'(c_l), 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule